// File: doc/BRIEF.md
# SPI bit-clock prescaler with mantissa and exponent divide ratio

This block turns the core clock into the serial bit clock of an SPI master. The divide ratio comes from an 8-bit prescale field. A 4-bit mantissa is multiplied by a power of two, and the exponent's three bits sit in two separate places in the field. A second, legacy encoding gives an even divisor directly. The block drives the bit clock level and two single-cycle strobes, one on each clock edge, that a shift engine uses to launch and capture data.

Software computes the field from the target frequency. The block only decodes the field and checks it. It holds the bit clock low whenever the field describes no usable ratio. A new field takes effect only while the divider is stopped or at a period boundary, so a running clock is never cut short. The run input starts the divider from a known phase.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: With `legacy_mode`=0 the divide ratio N is M·2^E, where M = `prescale[3:0]` and E = {`prescale[7:6]`, `prescale[4]`} (bit 4 is the exponent's least significant bit). One `sclk` period lasts N core cycles.
- R2: With `legacy_mode`=0, `prescale[5]` has no effect on the ratio.
- R3: With `legacy_mode`=1 the field is valid only when `prescale[4]`=1 and `prescale[3:0]` is at least 2. N is then 2·`prescale[3:0]` (even values from 4 to 30), and `prescale[7:5]` are ignored.
- R4: A field that gives N < 2 (mantissa 0 or 1 with exponent 0 in exponent mode, or an invalid legacy field) sets `cfg_bad`=1. While it is in force, `sclk` stays low and no strobe occurs, even with `run`=1.
- R5: Within a period, `sclk` is low for floor(N/2) cycles and then high for ceil(N/2) cycles. For odd N the high phase is one cycle longer.
- R6: `lead_stb` pulses for exactly one cycle in the cycle in which `sclk` first reads 1. `trail_stb` pulses for one cycle in the cycle in which `sclk` first reads 0 at the end of a period. The two never occur together.
- R7: While `run`=0, `sclk` is low, no strobe occurs and the phase counter is cleared. After `run` rises, the first rising `sclk` edge comes at the floor(N/2)-th clock edge that samples `run`=1.
- R8: A `prescale` or `legacy_mode` change while the divider runs is taken at the next period boundary. The period in progress completes with the old ratio.
- R9: Synchronous reset drives `sclk`, `lead_stb` and `trail_stb` to 0 and marks the configuration invalid (`cfg_bad`=1). The configuration loads on the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Divider runs while high |
| legacy_mode | input | 1 | 1 selects the even-divisor encoding |
| prescale | input | 8 | Divide-ratio field |
| sclk | output | 1 | Bit clock level, idle low |
| lead_stb | output | 1 | One-cycle pulse on each rising bit-clock edge |
| trail_stb | output | 1 | One-cycle pulse on each falling bit-clock edge at a period end |
| cfg_bad | output | 1 | The configuration in force gives no usable ratio |

## Verification
The hardest case to reach from the ports is a field change that lands part-way through a running period. It must not disturb that period, and it must take hold exactly at the wrap. The stimulus starts a short ratio and rewrites the field one cycle after the divider starts. The expected strobe cycles are queued for one old period followed by new ones, so a change taken early or late shows up as a mismatched cycle number. Stopping `run` during a high phase and then restarting checks that the clock drops without a trailing strobe and that the restart begins a fresh low half.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;

    localparam int PRE_W   = 8;
    localparam int MANT_W  = 4;
    localparam int EXP_W   = 3;
    localparam int RATIO_W = MANT_W + (1 << EXP_W) - 1;
    localparam int MIN_RATIO = 2;

    // Field positions; the exponent is split around an unused bit
    localparam int EXP_LO_BIT  = 4;
    localparam int EXP_HI_MSB  = 7;
    localparam int EXP_HI_LSB  = 6;
    localparam int LEG_EN_BIT  = 4;

    typedef enum logic {
        ENC_EXPONENT = 1'b0,
        ENC_LEGACY   = 1'b1
    } enc_mode_e;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [RATIO_W-1:0] low_len;
        logic               ok;
    } div_cfg_t;

    function automatic logic [MANT_W-1:0] mant_of(input logic [PRE_W-1:0] f);
        return f[MANT_W-1:0];
    endfunction

    function automatic logic [EXP_W-1:0] exp_of(input logic [PRE_W-1:0] f);
        return {f[EXP_HI_MSB:EXP_HI_LSB], f[EXP_LO_BIT]};
    endfunction

endpackage

// File: rtl/spi_div_decode.sv
module spi_div_decode
    import spi_div_pkg::*;
(
    input  logic             legacy_mode,
    input  logic [PRE_W-1:0] prescale,
    output div_cfg_t         cfg
);
    enc_mode_e          mode;
    logic [MANT_W-1:0]  mant;
    logic [EXP_W-1:0]   expn;
    logic [RATIO_W-1:0] ratio_exp;
    logic [RATIO_W-1:0] ratio_leg;
    logic               ok_exp;
    logic               ok_leg;

    always_comb begin
        mode      = enc_mode_e'(legacy_mode);
        mant      = mant_of(prescale);
        expn      = exp_of(prescale);
        ratio_exp = RATIO_W'(mant) << expn;
        ratio_leg = RATIO_W'({mant, 1'b0});
        ok_exp    = ratio_exp >= RATIO_W'(MIN_RATIO);
        ok_leg    = prescale[LEG_EN_BIT] && (ratio_leg >= RATIO_W'(2 * MIN_RATIO));
        if (mode == ENC_LEGACY) begin
            cfg.ratio = ratio_leg;
            cfg.ok    = ok_leg;
        end else begin
            cfg.ratio = ratio_exp;
            cfg.ok    = ok_exp;
        end
        cfg.low_len = cfg.ratio >> 1;
    end
endmodule

// File: rtl/spi_div_shadow.sv
module spi_div_shadow
    import spi_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  div_cfg_t cfg_d,
    output div_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/spi_div_phase.sv
module spi_div_phase
    import spi_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  div_cfg_t cfg,
    output logic     at_wrap,
    output logic     sclk,
    output logic     lead_stb,
    output logic     trail_stb
);
    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] cnt_n;
    logic               active;

    always_comb begin
        active  = run && cfg.ok;
        at_wrap = active && (cnt == cfg.ratio - RATIO_W'(1));
        cnt_n   = at_wrap ? '0 : cnt + RATIO_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt       <= '0;
            sclk      <= 1'b0;
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
        end else begin
            cnt       <= cnt_n;
            sclk      <= cnt_n >= cfg.low_len;
            lead_stb  <= cnt_n == cfg.low_len;
            trail_stb <= cnt_n == '0;
        end
    end
endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler
    import spi_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             legacy_mode,
    input  logic [PRE_W-1:0] prescale,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb,
    output logic             cfg_bad
);
    div_cfg_t cfg_new;
    div_cfg_t cfg_cur;
    logic     at_wrap;
    logic     load_cfg;

    spi_div_decode u_decode (
        .legacy_mode (legacy_mode),
        .prescale    (prescale),
        .cfg         (cfg_new)
    );

    // Take a new ratio only when no period is in flight
    assign load_cfg = !run || !cfg_cur.ok || at_wrap;

    spi_div_shadow u_shadow (
        .clk   (clk),
        .rst   (rst),
        .load  (load_cfg),
        .cfg_d (cfg_new),
        .cfg_q (cfg_cur)
    );

    spi_div_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .cfg       (cfg_cur),
        .at_wrap   (at_wrap),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    assign cfg_bad = !cfg_cur.ok;
endmodule

// File: rtl/spi_sclk_prescaler_chk.sv
module spi_sclk_prescaler_chk (
    input logic clk,
    input logic rst,
    input logic run,
    input logic sclk,
    input logic lead_stb,
    input logic trail_stb,
    input logic cfg_bad
);
    assert_lead_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
        lead_stb |-> (sclk && !$past(sclk)));

    assert_trail_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        trail_stb |-> (!sclk && $past(sclk)));

    assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(lead_stb && trail_stb));

    assert_rise_has_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> lead_stb);

    assert_run_fall_has_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(sclk) && $past(run)) |-> trail_stb);

    assert_bad_cfg_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_bad |-> (!sclk && !lead_stb));

    assert_stopped_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!sclk && !lead_stb && !trail_stb));
endmodule

bind spi_sclk_prescaler spi_sclk_prescaler_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb),
    .cfg_bad   (cfg_bad)
);

// File: tb/spi_sclk_prescaler_bench.sv
`timescale 1ns/1ps
module spi_sclk_prescaler_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic       legacy_mode = 1'b0;
    logic [7:0] prescale = 8'h04;
    logic       sclk, lead_stb, trail_stb, cfg_bad;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int strobe_cnt = 0;
    bit prev_sclk = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        bit    trail;
        int    at;
        string req;
    } evt_t;
    evt_t expq[$];

    always #2 clk = ~clk;

    spi_sclk_prescaler u_spi_sclk_prescaler (
        .clk(clk), .rst(rst), .run(run), .legacy_mode(legacy_mode),
        .prescale(prescale), .sclk(sclk), .lead_stb(lead_stb),
        .trail_stb(trail_stb), .cfg_bad(cfg_bad)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Expected ratio worked out from the field rules of R1-style encoding
    function automatic int exp_ratio(input logic [7:0] f, input bit leg, output bit valid);
        int r;
        if (leg) begin
            r = 2 * int'(f[3:0]);
            valid = f[4] && (f[3:0] >= 2);
        end else begin
            r = int'(f[3:0]) * (1 << (2 * int'(f[7:6]) + int'(f[4])));
            valid = r >= 2;
        end
        return r;
    endfunction

    task automatic compare_evt(input bit is_trail);
        evt_t e;
        if (expq.size() == 0) begin
            check(1'b0, "R7 unexpected strobe", int'(is_trail), -1);
        end else begin
            e = expq.pop_front();
            check(e.trail == is_trail, {e.req, " strobe kind"}, int'(is_trail), int'(e.trail));
            check(e.at == cyc, {e.req, " strobe cycle"}, cyc, e.at);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (lead_stb) begin
                strobe_cnt++;
                check(sclk && !prev_sclk, "R6 lead aligned with rise", int'(sclk), 1);
                compare_evt(1'b0);
            end
            if (trail_stb) begin
                strobe_cnt++;
                check(!sclk && prev_sclk, "R6 trail aligned with fall", int'(sclk), 0);
                compare_evt(1'b1);
            end
        end
        prev_sclk = sclk;
    end

    task automatic push_periods(input int base, input int n, input int nper, input string req);
        for (int p = 0; p < nper; p++) begin
            expq.push_back('{1'b0, base + p * n + n / 2, req});
            expq.push_back('{1'b1, base + p * n + n, req});
        end
    endtask

    task automatic run_case(input logic [7:0] f, input bit leg, input int nper, input string req);
        int  n, c;
        bit  v;
        @(negedge clk);
        run = 1'b0; prescale = f; legacy_mode = leg;
        repeat (2) @(negedge clk);
        n = exp_ratio(f, leg, v);
        #1;
        check(cfg_bad == 1'b0, {req, " field valid"}, int'(cfg_bad), 0);
        @(negedge clk);
        c = cyc;
        run = 1'b1;
        push_periods(c, n, nper, req);
        while (cyc < c + nper * n) @(negedge clk);
        run = 1'b0;
        @(negedge clk); #1;
        check(expq.size() == 0, {req, " all edges seen"}, expq.size(), 0);
        check(sclk == 1'b0, {req, " idle after stop"}, int'(sclk), 0);
        expq.delete();
    endtask

    task automatic bad_case(input logic [7:0] f, input bit leg, input string req);
        int  s0;
        bit  hi = 1'b0;
        @(negedge clk);
        run = 1'b0; prescale = f; legacy_mode = leg;
        repeat (2) @(negedge clk); #1;
        check(cfg_bad == 1'b1, {req, " flagged"}, int'(cfg_bad), 1);
        s0 = strobe_cnt;
        run = 1'b1;
        repeat (40) begin
            @(negedge clk); #1;
            if (sclk) hi = 1'b1;
        end
        check(!hi, {req, " sclk held low"}, int'(hi), 0);
        check(strobe_cnt == s0, {req, " no strobes"}, strobe_cnt - s0, 0);
        run = 1'b0;
    endtask

    initial begin
        int c, s0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(cfg_bad == 1'b1, "R9 cfg_bad in reset", int'(cfg_bad), 1);
        check(sclk == 1'b0 && !lead_stb && !trail_stb, "R9 outputs low in reset",
              int'(sclk | lead_stb | trail_stb), 0);
        rst = 1'b0;
        @(negedge clk); #1;
        check(cfg_bad == 1'b0, "R9 config loads after reset", int'(cfg_bad), 0);

        run_case(8'h03, 1'b0, 3, "R5 odd ratio 3");
        run_case(8'h15, 1'b0, 2, "R1 exponent bit4 ratio 10");
        run_case(8'h42, 1'b0, 2, "R1 exponent bits7:6 ratio 8");
        run_case(8'h27, 1'b0, 2, "R2 bit5 ignored ratio 7");
        run_case(8'h07, 1'b0, 1, "R2 reference ratio 7");
        run_case(8'h09, 1'b0, 2, "R5 odd ratio 9");
        run_case(8'hD3, 1'b0, 1, "R1 max exponent ratio 384");
        run_case(8'h13, 1'b1, 2, "R3 legacy ratio 6");
        run_case(8'hF5, 1'b1, 2, "R3 legacy high bits ignored ratio 10");
        run_case(8'h1F, 1'b1, 1, "R3 legacy ratio 30");
        run_case(8'h12, 1'b1, 2, "R3 legacy ratio 4");

        bad_case(8'h00, 1'b0, "R4 mantissa zero");
        bad_case(8'h01, 1'b0, "R4 ratio one");
        bad_case(8'h05, 1'b1, "R4 legacy bit4 clear");
        bad_case(8'h11, 1'b1, "R4 legacy divisor two");

        // R8: rewrite the field one cycle into a running period
        @(negedge clk);
        run = 1'b0; legacy_mode = 1'b0; prescale = 8'h04;
        repeat (2) @(negedge clk);
        c = cyc;
        run = 1'b1;
        push_periods(c, 4, 1, "R8 old period");
        push_periods(c + 4, 6, 2, "R8 new ratio");
        @(negedge clk);
        prescale = 8'h06;
        while (cyc < c + 16) @(negedge clk);
        run = 1'b0;
        @(negedge clk); #1;
        check(expq.size() == 0, "R8 all edges seen", expq.size(), 0);
        expq.delete();

        // R7: stop during the high phase, then restart
        @(negedge clk);
        prescale = 8'h08;
        repeat (2) @(negedge clk);
        c = cyc;
        run = 1'b1;
        expq.push_back('{1'b0, c + 4, "R7 first rise"});
        while (cyc < c + 4) @(negedge clk);
        #1;
        check(sclk == 1'b1, "R7 high before stop", int'(sclk), 1);
        s0 = strobe_cnt;
        run = 1'b0;
        @(negedge clk); #1;
        check(sclk == 1'b0, "R7 stop forces low", int'(sclk), 0);
        check(strobe_cnt == s0, "R7 no trail on stop", strobe_cnt - s0, 0);
        run_case(8'h08, 1'b0, 1, "R7 restart half period");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule